// File: doc/BRIEF.md
# Link Error Statistics Counter Bank

This block holds the error statistics of a bit-oriented link controller. It has seven 16-bit counters, one for each kind of link trouble: damaged received frames, frame-reject frames received, retransmission-timer expiries, reject frames received, reject frames sent, runt frames, and aborted received frames. The framing logic raises a one-cycle strobe for each event. The block then reads, increments and writes back the matching counter in that same clock edge. It only ever counts upward and never resets a counter by itself. Clearing and presetting are left to the host.

The host uses a small word-addressed port. Word index k, which sits at byte offset 2k from the start of the statistics area, selects counter k. Word index 7 is a reserved word. A host read returns data one cycle after the request, and a small two-state port machine marks that data as valid. The state PORT_IDLE goes to PORT_RESP on a read request. PORT_RESP stays in PORT_RESP on a back-to-back read and goes back to PORT_IDLE otherwise. A host write overwrites a counter at the next edge.

Top module: `linkstat_bank`

## Requirements
- R1: After reset all seven counters read 0. Word index k reads counter k. The index-to-event mapping is: 0 damaged frame, 1 frame-reject received, 2 retransmission-timer expiry, 3 reject received, 4 reject sent, 5 runt frame, 6 aborted frame.
- R2: A strobe on one counter's event raises that counter by exactly one at the next edge. Strobe bits are mapped as follows: bit 0 is an FCS error, bit 1 is a non-octet-aligned frame, and bit j (j from 2 to 7) counts into counter j-1.
- R3: A counter at 0xFFFF goes to 0x0000 on an increment.
- R4: Strobes that arrive in the same cycle on different counters each raise their own counter by one, and no event is lost.
- R5: Bit 7 (aborted frame) has no effect unless `abort_count_en_i` is 1 in that cycle.
- R6: A host write (`host_sel_i`=1, `host_wr_i`=1) to index k<7 loads `host_wdata_i` into counter k at the next edge.
- R7: When a host write and an increment target the same counter in the same cycle, the counter takes the written value and the increment is dropped.
- R8: A host read (`host_sel_i`=1, `host_wr_i`=0) sets `host_rvalid_o` for exactly one cycle, one cycle after the request. `host_rdata_o` then carries the counter value from before the request edge, and the read changes no counter.
- R9: Word index 7 always reads 0, and a write to it changes no counter.
- R10: Bits 0 and 1 both count into counter 0. When both are set in one cycle, counter 0 rises by one only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_i | input | 8 | Event strobes, one cycle each |
| abort_count_en_i | input | 1 | Enables counting of aborted frames |
| host_sel_i | input | 1 | Host access request |
| host_wr_i | input | 1 | 1 = write, 0 = read |
| host_addr_i | input | 3 | Word index |
| host_wdata_i | input | 16 | Write data |
| host_rdata_o | output | 16 | Read data |
| host_rvalid_o | output | 1 | Read data valid |

## Verification
The bench drives single strobes one bit at a time so that any crossed wiring between event and counter shows up. It then drives both damaged-frame causes together, which separates an OR into one counter from a summing count. An all-strobes burst checks that no event is lost when many arrive at once. The aborted-frame bit is driven with the enable both high and low. A counter is preset near the top so the wrap can be seen. Writes land in the same cycle as strobes to show which one has priority. Reads are issued in the same cycle as an increment, to confirm that the pre-edge value comes back.

// File: rtl/linkstat_pkg.sv
package linkstat_pkg;
    localparam int CNT_W     = 16;
    localparam int NUM_CNT   = 7;
    localparam int ADDR_W    = 3;
    localparam int NUM_EVT   = NUM_CNT + 1;
    localparam int ABORT_IDX = NUM_CNT - 1;

    typedef enum logic {
        PORT_IDLE = 1'b0,
        PORT_RESP = 1'b1
    } port_state_t;
endpackage

// File: rtl/linkstat_evt_map.sv
module linkstat_evt_map #(
    parameter int NUM_CNT   = linkstat_pkg::NUM_CNT,
    parameter int ABORT_IDX = linkstat_pkg::ABORT_IDX,
    localparam int NUM_EVT  = NUM_CNT + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] ev_i,
    input  logic               abort_en_i,
    output logic [NUM_CNT-1:0] inc_o
);
    // two causes of a damaged frame share counter 0
    assign inc_o[0] = ev_i[0] | ev_i[1];

    for (genvar k = 1; k < NUM_CNT; k++) begin : g_map
        if (k == ABORT_IDX) begin : g_gated
            assign inc_o[k] = ev_i[k+1] & abort_en_i;
        end else begin : g_plain
            assign inc_o[k] = ev_i[k+1];
        end
    end

    assert_abort_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !abort_en_i |-> !inc_o[ABORT_IDX]);
    assert_bad_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i[0] || ev_i[1]) |-> inc_o[0]);
endmodule

// File: rtl/linkstat_cnt_slot.sv
module linkstat_cnt_slot #(
    parameter int CNT_W = linkstat_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (wr_i)  cnt_q <= wdata_i;        // host has priority
        else if (inc_i) cnt_q <= cnt_q + ONE;    // natural wrap
    end

    assign cnt_o = cnt_q;

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !wr_i) |=> cnt_q == $past(cnt_q) + ONE);
    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !wr_i && cnt_q == TOP) |=> cnt_q == '0);
    assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> cnt_q == $past(wdata_i));
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !wr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/linkstat_rd_port.sv
module linkstat_rd_port #(
    parameter int CNT_W   = linkstat_pkg::CNT_W,
    parameter int NUM_CNT = linkstat_pkg::NUM_CNT,
    parameter int ADDR_W  = linkstat_pkg::ADDR_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_i,
    output logic [CNT_W-1:0]               rdata_o,
    output logic                           rvalid_o
);
    import linkstat_pkg::*;

    port_state_t      state_q, state_d;
    logic [CNT_W-1:0] sel_val;
    logic [CNT_W-1:0] rdata_q;

    always_comb begin
        sel_val = '0;
        if (int'(addr_i) < NUM_CNT) sel_val = cnt_i[addr_i];
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PORT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PORT_IDLE: if (req_i)  state_d = PORT_RESP;
            PORT_RESP: if (!req_i) state_d = PORT_IDLE;
            default:               state_d = PORT_IDLE;
        endcase
    end

    // output process
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (req_i) rdata_q <= sel_val;
    end

    assign rvalid_o = (state_q == PORT_RESP);
    assign rdata_o  = rdata_q;

    assert_rvalid_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> rvalid_o);
    assert_rvalid_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !rvalid_o);
    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && int'(addr_i) >= NUM_CNT) |=> rdata_o == '0);
endmodule

// File: rtl/linkstat_bank.sv
module linkstat_bank #(
    parameter int CNT_W     = linkstat_pkg::CNT_W,
    parameter int NUM_CNT   = linkstat_pkg::NUM_CNT,
    parameter int ADDR_W    = linkstat_pkg::ADDR_W,
    parameter int ABORT_IDX = linkstat_pkg::ABORT_IDX,
    localparam int NUM_EVT  = NUM_CNT + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] ev_i,
    input  logic               abort_count_en_i,
    input  logic               host_sel_i,
    input  logic               host_wr_i,
    input  logic [ADDR_W-1:0]  host_addr_i,
    input  logic [CNT_W-1:0]   host_wdata_i,
    output logic [CNT_W-1:0]   host_rdata_o,
    output logic               host_rvalid_o
);
    logic [NUM_CNT-1:0]            inc;
    logic [NUM_CNT-1:0]            wr_hit;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
    logic                          rd_req;

    assign rd_req = host_sel_i && !host_wr_i;

    linkstat_evt_map #(
        .NUM_CNT   (NUM_CNT),
        .ABORT_IDX (ABORT_IDX)
    ) u_evt_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_i       (ev_i),
        .abort_en_i (abort_count_en_i),
        .inc_o      (inc)
    );

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_slot
        assign wr_hit[k] = host_sel_i && host_wr_i && (int'(host_addr_i) == k);

        linkstat_cnt_slot #(.CNT_W(CNT_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc_i   (inc[k]),
            .wr_i    (wr_hit[k]),
            .wdata_i (host_wdata_i),
            .cnt_o   (cnt[k])
        );
    end

    linkstat_rd_port #(
        .CNT_W   (CNT_W),
        .NUM_CNT (NUM_CNT),
        .ADDR_W  (ADDR_W)
    ) u_rd_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (rd_req),
        .addr_i   (host_addr_i),
        .cnt_i    (cnt),
        .rdata_o  (host_rdata_o),
        .rvalid_o (host_rvalid_o)
    );

    assert_one_writer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_hit));
endmodule

// File: tb/test_linkstat_bank.sv
module test_linkstat_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ev = '0;
    logic        en = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        rvalid;

    int checks = 0;
    int fails  = 0;
    logic [15:0] model [7];
    logic [15:0] exp_q [$];
    string       req_q [$];

    always #2 clk = ~clk;

    linkstat_bank i_linkstat_bank (
        .clk(clk), .rst_n(rst_n), .ev_i(ev), .abort_count_en_i(en),
        .host_sel_i(sel), .host_wr_i(wr), .host_addr_i(addr),
        .host_wdata_i(wdata), .host_rdata_o(rdata), .host_rvalid_o(rvalid)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expected read results
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R8 actual=unexpected_rvalid expected=no_rvalid");
            end else begin
                check(req_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    // driver: one cycle of stimulus; model follows the requirements
    task automatic step(logic [7:0] e, logic ab, logic s, logic w,
                        logic [2:0] a, logic [15:0] d, string req);
        logic [6:0] inc;
        @(negedge clk);
        ev = e; en = ab; sel = s; wr = w; addr = a; wdata = d;
        if (s && !w) begin
            exp_q.push_back((a < 3'd7) ? model[a] : 16'h0000);
            req_q.push_back(req);
        end
        inc[0] = e[0] | e[1];
        for (int k = 1; k < 6; k++) inc[k] = e[k+1];
        inc[6] = e[7] & ab;
        for (int k = 0; k < 7; k++) if (inc[k]) model[k] = model[k] + 16'd1;
        if (s && w && a < 3'd7) model[a] = d;
        @(posedge clk);
    endtask

    task automatic idle();
        step(8'h00, 1'b0, 1'b0, 1'b0, 3'd0, 16'h0, "");
    endtask

    task automatic read_all(string req);
        for (int k = 0; k < 8; k++) step(8'h00, 1'b0, 1'b1, 1'b0, 3'(k), 16'h0, req);
        idle();
        idle();
    endtask

    initial begin
        #(4 * 200000);
        checks++; fails++;
        $display("FAIL R8 actual=watchdog_expired expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < 7; k++) model[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset rvalid", {15'b0, rvalid}, 16'h0);
        rst_n = 1'b1;
        read_all("R1 reset value");

        // single strobe per bit
        for (int b = 0; b < 8; b++) step(8'(1 << b), 1'b1, 1'b0, 1'b0, 3'd0, 16'h0, "");
        idle();
        read_all("R2 single strobe mapping");

        // both damaged-frame causes together count once
        step(8'h03, 1'b1, 1'b0, 1'b0, 3'd0, 16'h0, "");
        idle();
        step(8'h00, 1'b0, 1'b1, 1'b0, 3'd0, 16'h0, "R10 merged causes");
        idle();

        // all strobes at once
        step(8'hFF, 1'b1, 1'b0, 1'b0, 3'd0, 16'h0, "");
        step(8'hFE, 1'b1, 1'b0, 1'b0, 3'd0, 16'h0, "");
        read_all("R4 simultaneous strobes");

        // aborted frame with enable off
        step(8'h80, 1'b0, 1'b0, 1'b0, 3'd0, 16'h0, "");
        step(8'h80, 1'b0, 1'b0, 1'b0, 3'd0, 16'h0, "");
        step(8'h00, 1'b0, 1'b1, 1'b0, 3'd6, 16'h0, "R5 abort gated off");
        step(8'h80, 1'b1, 1'b0, 1'b0, 3'd0, 16'h0, "");
        step(8'h00, 1'b0, 1'b1, 1'b0, 3'd6, 16'h0, "R5 abort gated on");
        idle();

        // preset and wrap
        step(8'h00, 1'b0, 1'b1, 1'b1, 3'd3, 16'hFFFE, "");
        step(8'h00, 1'b0, 1'b1, 1'b0, 3'd3, 16'h0, "R6 preset");
        step(8'h10, 1'b0, 1'b0, 1'b0, 3'd0, 16'h0, "");
        step(8'h00, 1'b0, 1'b1, 1'b0, 3'd3, 16'h0, "R3 at top");
        step(8'h10, 1'b0, 1'b0, 1'b0, 3'd0, 16'h0, "");
        step(8'h00, 1'b0, 1'b1, 1'b0, 3'd3, 16'h0, "R3 wrapped");
        step(8'h00, 1'b0, 1'b1, 1'b1, 3'd0, 16'h0, "");
        step(8'h00, 1'b0, 1'b1, 1'b0, 3'd0, 16'h0, "R6 clear");
        idle();

        // write and increment collide
        step(8'h20, 1'b0, 1'b1, 1'b1, 3'd4, 16'h1234, "");
        step(8'h00, 1'b0, 1'b1, 1'b0, 3'd4, 16'h0, "R7 write wins");
        step(8'h21, 1'b0, 1'b1, 1'b1, 3'd4, 16'h0050, "");
        step(8'h00, 1'b0, 1'b1, 1'b0, 3'd0, 16'h0, "R7 other counter kept");
        step(8'h00, 1'b0, 1'b1, 1'b0, 3'd4, 16'h0, "R7 write wins again");
        idle();

        // reserved word
        step(8'h00, 1'b0, 1'b1, 1'b1, 3'd7, 16'hBEEF, "");
        read_all("R9 reserved write ignored");

        // read in same cycle as increment returns old value; repeat read
        step(8'h04, 1'b0, 1'b1, 1'b0, 3'd1, 16'h0, "R8 pre-edge value");
        step(8'h00, 1'b0, 1'b1, 1'b0, 3'd1, 16'h0, "R8 after increment");
        step(8'h00, 1'b0, 1'b1, 1'b0, 3'd1, 16'h0, "R8 no side effect");
        idle();
        idle();
        @(negedge clk);
        check("R8 rvalid drops", {15'b0, rvalid}, 16'h0);
        check("R8 pending reads", 16'(exp_q.size()), 16'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule